// File: doc/BRIEF.md
# NAND ECC Syndrome Decoder

This block checks a sector after it has been read from NAND flash. It takes two 3-byte Hamming-style codes. One code was stored in the spare area. The other was recomputed over the 512 data bytes just read. The block reorders each code into a 24-bit word and XORs the two words into a syndrome. It then decides which of four cases applies: the sector is clean, a single data bit can be repaired, only the stored code is damaged, or the damage cannot be repaired.

For a repairable data error, the block reports the 9-bit byte offset inside the sector and the 3-bit position inside that byte. The caller flips that bit in its own buffer. The block does not touch any sector buffer.

A check is started by a one-cycle strobe. One clock later the registered result appears together with a one-cycle valid pulse. The result stays on the outputs until the next strobe.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: Each code port carries three bytes as {c2, c1, c0}, with c2 in bits 23:16 and c0 in bits 7:0. Each code is reordered into the word {c2[1:0], c1, c0, c2[7:2]}. The syndrome is the XOR of the two reordered words.
- R2: When the two codes are equal, the status is 2'b00 (clean) and the address and bit outputs are zero.
- R3: The syndrome is split into 12 pairs, each pair being bits 2k and 2k+1. If every pair has at least one bit set, the status is 2'b01 (data bit repairable). This case takes priority over R6.
- R4: In the repairable case, the bit output is {s[5], s[3], s[1]}, with s[1] as the least significant bit.
- R5: In the repairable case, the byte address is {s[23], s[21], ..., s[9], s[7]}, with s[7] as the least significant bit.
- R6: If the syndrome has exactly one bit set, the status is 2'b10 (stored code damaged, data good).
- R7: Any other nonzero syndrome gives status 2'b11 (uncorrectable).
- R8: The valid output is high in exactly the cycle after a cycle in which the check strobe was sampled high, and low otherwise.
- R9: The address and bit outputs are zero whenever the status is not 2'b01.
- R10: Status, address and bit change only on a clock edge that samples the strobe high. Between checks they hold their values. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_i | input | 1 | Start-of-check strobe; both codes are sampled on this edge |
| rd_ecc_i | input | 24 | Code read from flash, {c2, c1, c0} |
| calc_ecc_i | input | 24 | Code recomputed over the sector, {c2, c1, c0} |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| status_o | output | 2 | 00 clean, 01 data repairable, 10 code-only damage, 11 uncorrectable |
| byte_addr_o | output | 9 | Offset of the failing byte in the sector |
| bit_idx_o | output | 3 | Position of the failing bit in that byte |

## Verification
Every result is due exactly one clock after the edge that samples the strobe. The bench drives each code pair and the strobe on a falling edge. A behavioural model captures the inputs on the next rising edge. Outputs are compared against the model on the following falling edge, so each comparison lands half a cycle after the register has updated.

On every cycle the bench checks valid against the strobe of the previous cycle. On cycles without a strobe it checks that the result outputs still hold their old values.

The stimulus covers:
- every single-bit data error position;
- every single-bit code error;
- hand-built syndromes with known addresses;
- the all-ones syndrome;
- random code pairs.

// File: rtl/ecc_dec_pkg.sv
package ecc_dec_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'b00,
    ST_DATA_FIX  = 2'b01,
    ST_CODE_ONLY = 2'b10,
    ST_FATAL     = 2'b11
  } ecc_status_e;

endpackage

// File: rtl/ecc_code_pack.sv
// Reorders a 3-byte code {c2, c1, c0} into the ascending 24-bit word used
// for the syndrome: {c2[1:0], c1, c0, c2[7:2]}.
module ecc_code_pack #(
  parameter int BYTE_W = 8,
  parameter int LOW_SH = 2
) (
  input  logic [3*BYTE_W-1:0] code_i,
  output logic [3*BYTE_W-1:0] word_o
);
  localparam int CODE_W = 3 * BYTE_W;

  logic [BYTE_W-1:0] c0, c1, c2;

  assign c0 = code_i[BYTE_W-1:0];
  assign c1 = code_i[2*BYTE_W-1:BYTE_W];
  assign c2 = code_i[CODE_W-1:2*BYTE_W];

  // c2's top bits fill the bottom of the word, its low bits fill the top.
  assign word_o = {c2[LOW_SH-1:0], c1, c0, c2[BYTE_W-1:LOW_SH]};

endmodule

// File: rtl/ecc_syn_classify.sv
// Combinational classification of a syndrome word.
module ecc_syn_classify
  import ecc_dec_pkg::*;
#(
  parameter int BIT_W  = 3,
  parameter int ADDR_W = 9
) (
  input  logic [2*(BIT_W+ADDR_W)-1:0] syn_i,
  output ecc_status_e                 status_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [BIT_W-1:0]            bit_o
);
  localparam int PAIRS = BIT_W + ADDR_W;
  localparam int SYN_W = 2 * PAIRS;

  logic [PAIRS-1:0]  pair_hit;
  logic [ADDR_W-1:0] addr_raw;
  logic [BIT_W-1:0]  bit_raw;
  logic              syn_zero;
  logic              syn_single;
  logic              all_pairs;

  // One hit flag per complementary pair.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_hit[k] = syn_i[2*k] | syn_i[2*k+1];
  end

  // The upper (odd) bit of each low pair gives the bit position.
  for (genvar i = 0; i < BIT_W; i++) begin : g_bit
    assign bit_raw[i] = syn_i[2*i+1];
  end

  // The upper (odd) bit of each remaining pair gives the byte offset.
  for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
    assign addr_raw[j] = syn_i[2*(BIT_W+j)+1];
  end

  assign all_pairs  = &pair_hit;
  assign syn_zero   = ~|syn_i;
  assign syn_single = !syn_zero && ((syn_i & (syn_i - SYN_W'(1))) == '0);

  always_comb begin
    status_o = ST_FATAL;
    addr_o   = '0;
    bit_o    = '0;
    if (syn_zero) begin
      status_o = ST_CLEAN;
    end else if (all_pairs) begin
      status_o = ST_DATA_FIX;
      addr_o   = addr_raw;
      bit_o    = bit_raw;
    end else if (syn_single) begin
      status_o = ST_CODE_ONLY;
    end
  end

endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
  import ecc_dec_pkg::*;
#(
  parameter int BIT_W  = 3,
  parameter int ADDR_W = 9
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            check_i,
  input  logic [2*(BIT_W+ADDR_W)-1:0]     rd_ecc_i,
  input  logic [2*(BIT_W+ADDR_W)-1:0]     calc_ecc_i,
  output logic                            valid_o,
  output logic [1:0]                      status_o,
  output logic [ADDR_W-1:0]               byte_addr_o,
  output logic [BIT_W-1:0]                bit_idx_o
);
  localparam int SYN_W  = 2 * (BIT_W + ADDR_W);
  localparam int BYTE_W = SYN_W / 3;

  logic [SYN_W-1:0]  rd_word, calc_word, syn;
  ecc_status_e       cls_status;
  logic [ADDR_W-1:0] cls_addr;
  logic [BIT_W-1:0]  cls_bit;

  ecc_code_pack #(.BYTE_W(BYTE_W), .LOW_SH(2)) u_pack_rd (
    .code_i (rd_ecc_i),
    .word_o (rd_word)
  );

  ecc_code_pack #(.BYTE_W(BYTE_W), .LOW_SH(2)) u_pack_calc (
    .code_i (calc_ecc_i),
    .word_o (calc_word)
  );

  assign syn = rd_word ^ calc_word;

  ecc_syn_classify #(.BIT_W(BIT_W), .ADDR_W(ADDR_W)) u_classify (
    .syn_i    (syn),
    .status_o (cls_status),
    .addr_o   (cls_addr),
    .bit_o    (cls_bit)
  );

  // Single register stage; the result is held until the next strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      status_o    <= 2'b00;
      byte_addr_o <= '0;
      bit_idx_o   <= '0;
    end else begin
      valid_o <= check_i;
      if (check_i) begin
        status_o    <= cls_status;
        byte_addr_o <= cls_addr;
        bit_idx_o   <= cls_bit;
      end
    end
  end

  // R8: a strobe yields a pulse on the next cycle
  assert_valid_after_check_R8: assert property (@(posedge clk) disable iff (rst)
    check_i |=> valid_o);

  // R8: no strobe means no pulse on the next cycle
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !check_i |=> !valid_o);

  // R2: equal codes report clean
  assert_equal_is_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (check_i && (rd_ecc_i == calc_ecc_i)) |=> (status_o == 2'b00));

  // R6: reordering keeps the bit count, so one differing raw bit is code-only damage
  assert_single_is_code_R6: assert property (@(posedge clk) disable iff (rst)
    (check_i && ($countones(rd_ecc_i ^ calc_ecc_i) == 1)) |=> (status_o == 2'b10));

  // R9: address and bit stay zero outside the repairable case
  assert_loc_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (status_o != 2'b01) |-> (byte_addr_o == '0 && bit_idx_o == '0));

  // R10: results hold between strobes
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !check_i |=> ($stable(status_o) && $stable(byte_addr_o) && $stable(bit_idx_o)));

endmodule

// File: tb/tb_ecc_syndrome_decoder.sv
`timescale 1ns/1ps
module tb_ecc_syndrome_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        check = 1'b0;
  logic [23:0] rd_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic        valid;
  logic [1:0]  status;
  logic [8:0]  byte_addr;
  logic [2:0]  bit_idx;

  int checks = 0;
  int fails  = 0;

  // Reference model state: what the outputs should show.
  logic       m_valid = 1'b0;
  logic [1:0] m_status = 2'b00;
  int         m_addr = 0;
  int         m_bit = 0;

  always #5 clk = ~clk;

  ecc_syndrome_decoder dut (
    .clk         (clk),
    .rst         (rst),
    .check_i     (check),
    .rd_ecc_i    (rd_ecc),
    .calc_ecc_i  (calc_ecc),
    .valid_o     (valid),
    .status_o    (status),
    .byte_addr_o (byte_addr),
    .bit_idx_o   (bit_idx)
  );

  // R1: reorder {c2,c1,c0} with integer shifts
  function automatic int order_code(input logic [23:0] c);
    int b2 = int'(c[23:16]);
    int b1 = int'(c[15:8]);
    int b0 = int'(c[7:0]);
    return ((b2 << 22) | (b1 << 14) | (b0 << 6) | (b2 >> 2)) & 32'hFFFFFF;
  endfunction

  // Inverse of the reordering, used to build a code from a wanted syndrome.
  function automatic logic [23:0] unorder(input logic [23:0] p);
    return {p[5:0], p[23:22], p[21:14], p[13:6]};
  endfunction

  function automatic void model_eval(input logic [23:0] r, input logic [23:0] c,
                                     output logic [1:0] st, output int ad, output int bi);
    int s = order_code(r) ^ order_code(c);
    int ones = 0;
    for (int i = 0; i < 24; i++) ones += (s >> i) & 1;
    ad = 0;
    bi = 0;
    if (s == 0) begin
      st = 2'b00;
    end else if (((s | (s >> 1)) & 32'h555555) == 32'h555555) begin
      st = 2'b01;
      for (int i = 0; i < 3; i++) bi |= ((s >> (2*i+1)) & 1) << i;
      for (int j = 0; j < 9; j++) ad |= ((s >> (7+2*j)) & 1) << j;
    end else if (ones == 1) begin
      st = 2'b10;
    end else begin
      st = 2'b11;
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid  <= 1'b0;
      m_status <= 2'b00;
      m_addr   <= 0;
      m_bit    <= 0;
    end else begin
      m_valid <= check;
      if (check) begin
        logic [1:0] st;
        int ad, bi;
        model_eval(rd_ecc, calc_ecc, st, ad, bi);
        m_status <= st;
        m_addr   <= ad;
        m_bit    <= bi;
      end
    end
  end

  function automatic string tag_for(input logic [1:0] st);
    case (st)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Cycle-by-cycle comparison against the model, half a cycle after the edge.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (valid !== m_valid) begin
        fails++;
        $display("FAIL R8 valid actual=%0b expected=%0b", valid, m_valid);
      end
      checks++;
      if (status !== m_status) begin
        fails++;
        $display("FAIL %s/R10 status actual=%0b expected=%0b", tag_for(m_status), status, m_status);
      end
      checks++;
      if (int'(byte_addr) != m_addr) begin
        fails++;
        $display("FAIL %s addr actual=%0d expected=%0d", (m_status == 2'b01) ? "R5" : "R9", byte_addr, m_addr);
      end
      checks++;
      if (int'(bit_idx) != m_bit) begin
        fails++;
        $display("FAIL %s bit actual=%0d expected=%0d", (m_status == 2'b01) ? "R4" : "R9", bit_idx, m_bit);
      end
    end
  end

  task automatic strobe(input logic [23:0] r, input logic [23:0] c);
    @(negedge clk);
    rd_ecc   = r;
    calc_ecc = c;
    check    = 1'b1;
    @(negedge clk);
    check    = 1'b0;
  endtask

  // Directed check against hand-computed values, read just after the result edge.
  task automatic expect_now(input string tag, input logic [1:0] st, input int ad, input int bi);
    checks++;
    if (status !== st || int'(byte_addr) != ad || int'(bit_idx) != bi) begin
      fails++;
      $display("FAIL %s actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
               tag, status, byte_addr, bit_idx, st, ad, bi);
    end
  endtask

  // Syndrome for a repairable error at byte a, bit b: in each pair pick the
  // odd bit when the matching location bit is one.
  function automatic logic [23:0] fix_syn(input int a, input int b);
    logic [23:0] s = '0;
    int loc = (a << 3) | b;
    for (int k = 0; k < 12; k++) s[2*k + ((loc >> k) & 1)] = 1'b1;
    return s;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R10)
    checks++;
    if (valid !== 1'b0 || status !== 2'b00 || byte_addr !== '0 || bit_idx !== '0) begin
      fails++;
      $display("FAIL R10 reset actual=%0b/%0b/%0d/%0d expected=0/0/0/0", valid, status, byte_addr, bit_idx);
    end
    rst = 1'b0;

    // R1 directed: byte 1 bit 0, and byte 0 bit 1
    strobe(24'h000000, 24'h555556);
    expect_now("R1 addr1", 2'b01, 1, 0);
    strobe(24'h000000, 24'h595555);
    expect_now("R1 bit1", 2'b01, 0, 1);

    // R2 equal codes
    strobe(24'h123456, 24'h123456);
    expect_now("R2 equal", 2'b00, 0, 0);

    // R3/R4/R5: all-ones syndrome satisfies the pair test
    strobe(24'h000000, 24'hFFFFFF);
    expect_now("R3 all-ones", 2'b01, 511, 7);

    // R6 one code bit flipped; R9 location zero
    strobe(24'hA5A5A5, 24'hA5A5A4);
    expect_now("R6 code-only", 2'b10, 0, 0);

    // R7 two bits in one pair, all else clean
    strobe(24'h000000, 24'h000003);
    expect_now("R7 fatal", 2'b11, 0, 0);

    // R10 hold: idle cycles keep the last result
    repeat (4) @(negedge clk);
    expect_now("R10 hold", 2'b11, 0, 0);

    // Every repairable location, back-to-back strobes
    for (int a = 0; a < 512; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [23:0] r = 24'($urandom);
        @(negedge clk);
        rd_ecc   = r;
        calc_ecc = unorder(24'(order_code(r)) ^ fix_syn(a, b));
        check    = 1'b1;
      end
    end
    @(negedge clk);
    check = 1'b0;

    // Every single code-bit error
    for (int i = 0; i < 24; i++) begin
      logic [23:0] r = 24'($urandom);
      strobe(r, r ^ (24'h1 << i));
    end

    // Random pairs with random gaps
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rd_ecc   = 24'($urandom);
      calc_ecc = ($urandom % 4 == 0) ? rd_ecc : 24'($urandom);
      check    = 1'($urandom % 3 != 0);
    end
    @(negedge clk);
    check = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule